// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the combinational hazard logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). For each of the two ALU operands of the instruction in the execute stage, it picks where the operand comes from. The choices are the value latched in the decode/execute register, the result held in the execute/memory register, or the result held in the memory/writeback register. A result made in execute can therefore feed the very next instruction with no wait.

The second half of the block spots a load whose destination is read by the instruction right behind it in decode. For that case it asks for a single stall cycle. The program counter and the fetch/decode register hold their values, so the dependent instruction is decoded once more and the instruction after it is fetched once more. The control fields entering the decode/execute register are cleared, so the slot travels down the pipe as a no-op. One cycle later the loaded data sits in the memory/writeback register and is bypassed from there.

The register file writes in the first half of a cycle and reads in the second. The block therefore provides no bypass from writeback into decode.

Top module: `hz_unit`

## Requirements
- R1: Each operand select is a 2-bit code: 2'b00 takes the decode/execute register value, 2'b10 takes the execute/memory result, 2'b01 takes the memory/writeback result. 2'b11 never appears.
- R2: When the execute/memory stage writes a nonzero register equal to an operand's source register, that operand's select is 2'b10.
- R3: When only the memory/writeback stage writes a nonzero register equal to an operand's source, the select is 2'b01. This includes the load result one cycle after a load-use stall.
- R4: When both later stages write the operand's source register, the newer execute/memory result wins (2'b10).
- R5: A destination of register 0 never causes a bypass, even with its write enable high.
- R6: A stage whose write enable is low never causes a bypass, even when its destination matches.
- R7: A load in execute whose nonzero destination equals either decode source register drives pc_wr_en=0, ifid_wr_en=0 and idex_bubble=1 in the same cycle.
- R8: Without such a load match, pc_wr_en=1, ifid_wr_en=1 and idex_bubble=0. This holds for a load followed by an unrelated instruction and for a non-load producer followed by a consumer.
- R9: A load that targets register 0 never stalls, even when a decode source is also register 0.
- R10: The two operand selects are independent. Each depends only on its own source register, so one operand can take 2'b10 while the other takes 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register of the instruction in decode |
| id_src_b | input | REG_W | Second source register of the instruction in decode |
| ex_src_a | input | REG_W | First source register of the instruction in execute |
| ex_src_b | input | REG_W | Second source register of the instruction in execute |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | REG_W | Destination held in the execute/memory register |
| mem_wr_en | input | 1 | Register write enable held in the execute/memory register |
| wb_dst | input | REG_W | Destination held in the memory/writeback register |
| wb_wr_en | input | 1 | Register write enable held in the memory/writeback register |
| fwd_sel_a | output | 2 | Source select for ALU operand A |
| fwd_sel_b | output | 2 | Source select for ALU operand B |
| pc_wr_en | output | 1 | Program counter update enable (low during a stall) |
| ifid_wr_en | output | 1 | Fetch/decode register update enable (low during a stall) |
| idex_bubble | output | 1 | Clears control fields entering decode/execute (high during a stall) |

## Verification
Every time an input changes, the embedded assertions check the following:
- A select code is never the unused value.
- Register 0 and disabled writers never produce a bypass.
- The newer stage wins whenever both stages hit.
- The three stall outputs always move together.
- Only a load can cause a stall.

Only the bench scenarios show the rest:
- That a given source is routed to the correct stage.
- That the stall and the later writeback bypass line up across a load followed by its use.
- That an unrelated instruction after a load runs without stalling.
- That the two operands are resolved independently.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_IDEX = 2'b00,
    FWD_WB   = 2'b01,
    FWD_MEM  = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A producer supplies this operand when it writes a real register equal to the source
  function automatic logic producer_hits(
    input logic [REG_W-1:0] src,
    input logic [REG_W-1:0] dst,
    input logic             we
  );
    return we && (dst != ZERO_REG) && (dst == src);
  endfunction

  logic hit_mem;
  logic hit_wb;

  always_comb begin
    hit_mem = producer_hits(src_i, mem_dst_i, mem_we_i);
    hit_wb  = producer_hits(src_i, wb_dst_i, wb_we_i);
  end

  // Newer producer takes priority
  always_comb begin
    sel_o = FWD_IDEX;
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
  end

  always_comb begin
    assert_legal_code_R1: assert (sel_o != fwd_sel_e'(2'b11));
    if (src_i == ZERO_REG)
      assert_zero_reg_no_fwd_R5: assert (sel_o == FWD_IDEX);
    if (!mem_we_i && !wb_we_i)
      assert_we_low_no_fwd_R6: assert (sel_o == FWD_IDEX);
    if (hit_mem && hit_wb)
      assert_newer_wins_R4: assert (sel_o == FWD_MEM);
  end

endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  input  logic [REG_W-1:0]              ex_dst_i,
  input  logic                          ex_is_load_i,
  output logic                          pc_wr_en_o,
  output logic                          ifid_wr_en_o,
  output logic                          idex_bubble_o
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] src_hit;
  logic               load_live;
  logic               hazard;

  always_comb load_live = ex_is_load_i && (ex_dst_i != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = load_live && (id_src_i[g] == ex_dst_i);
  end

  always_comb begin
    hazard        = |src_hit;
    pc_wr_en_o    = !hazard;
    ifid_wr_en_o  = !hazard;
    idex_bubble_o = hazard;
  end

  always_comb begin
    assert_stall_group_R7: assert ((pc_wr_en_o == ifid_wr_en_o) && (idex_bubble_o == !pc_wr_en_o));
    if (!ex_is_load_i)
      assert_nonload_no_stall_R8: assert (pc_wr_en_o && !idex_bubble_o);
    if (ex_dst_i == ZERO_REG)
      assert_r0_load_no_stall_R9: assert (pc_wr_en_o);
  end

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             pc_wr_en,
  output logic             ifid_wr_en,
  output logic             idex_bubble
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] ex_src;
  logic [NUM_SRC-1:0][REG_W-1:0] id_src;
  fwd_sel_e                      sel [NUM_SRC];

  always_comb begin
    ex_src[0] = ex_src_a;
    ex_src[1] = ex_src_b;
    id_src[0] = id_src_a;
    id_src[1] = id_src_b;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    hz_operand_fwd #(.REG_W(REG_W)) u_fwd (
      .src_i     (ex_src[g]),
      .mem_dst_i (mem_dst),
      .mem_we_i  (mem_wr_en),
      .wb_dst_i  (wb_dst),
      .wb_we_i   (wb_wr_en),
      .sel_o     (sel[g])
    );
  end

  always_comb begin
    fwd_sel_a = sel[0];
    fwd_sel_b = sel[1];
  end

  hz_loaduse_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_lu (
    .id_src_i      (id_src),
    .ex_dst_i      (ex_dst),
    .ex_is_load_i  (ex_is_load),
    .pc_wr_en_o    (pc_wr_en),
    .ifid_wr_en_o  (ifid_wr_en),
    .idex_bubble_o (idex_bubble)
  );

endmodule

// File: tb/test_hz_unit.sv
module test_hz_unit;

  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
  logic [W-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic         ex_is_load = 1'b0, mem_wr_en = 1'b0, wb_wr_en = 1'b0;
  logic [1:0]   fwd_sel_a, fwd_sel_b;
  logic         pc_wr_en, ifid_wr_en, idex_bubble;

  hz_unit #(.REG_W(W)) i_hz_unit (
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .idex_bubble(idex_bubble)
  );

  typedef struct {
    logic [1:0] sel_a;
    logic [1:0] sel_b;
    logic       stall;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  // Expected select, from R1..R6: newer stage first, r0 and disabled writers ignored
  function automatic logic [1:0] want_sel(input logic [W-1:0] s, md, input logic mwe,
                                          input logic [W-1:0] wd, input logic wwe);
    if (mwe && md != 0 && md == s) return 2'b10;
    if (wwe && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input logic [W-1:0] ia, ib, ea, eb, ed, input logic ld,
                       input logic [W-1:0] md, input logic mwe,
                       input logic [W-1:0] wd, input logic wwe, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    id_src_a = ia; id_src_b = ib; ex_src_a = ea; ex_src_b = eb;
    ex_dst = ed; ex_is_load = ld; mem_dst = md; mem_wr_en = mwe;
    wb_dst = wd; wb_wr_en = wwe;
    e.sel_a = want_sel(ea, md, mwe, wd, wwe);
    e.sel_b = want_sel(eb, md, mwe, wd, wwe);
    e.stall = ld && (ed != 0) && (ed == ia || ed == ib);
    e.req   = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (fwd_sel_a !== e.sel_a) begin
        failures++;
        $display("FAIL %s fwd_sel_a actual=%b expected=%b", e.req, fwd_sel_a, e.sel_a);
      end
      checks++;
      if (fwd_sel_b !== e.sel_b) begin
        failures++;
        $display("FAIL %s fwd_sel_b actual=%b expected=%b", e.req, fwd_sel_b, e.sel_b);
      end
      checks++;
      if ({pc_wr_en, ifid_wr_en, idex_bubble} !== {!e.stall, !e.stall, e.stall}) begin
        failures++;
        $display("FAIL %s stall pc/ifid/bubble actual=%b%b%b expected=%b%b%b", e.req,
                 pc_wr_en, ifid_wr_en, idex_bubble, !e.stall, !e.stall, e.stall);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    //     ia  ib  ea  eb  ed  ld   md  mwe  wd  wwe
    drive( 0,  0,  0,  0,  0, 0,   0, 0,   0, 0, "R1 idle");
    drive( 0,  0,  3,  7,  0, 0,   3, 1,   0, 0, "R2 back-to-back a");
    drive( 0,  0,  6,  3,  0, 0,   3, 1,   0, 0, "R2 back-to-back b");
    drive( 0,  0,  9,  4,  0, 0,   0, 0,   4, 1, "R3 writeback b");
    drive( 0,  0,  4,  4,  0, 0,   4, 1,   4, 1, "R4 double match");
    drive( 0,  0,  0,  0,  0, 0,   0, 1,   0, 1, "R5 r0 writers");
    drive( 0,  0,  5,  8,  0, 0,   5, 0,   8, 0, "R6 write disabled");
    drive( 0,  0,  5,  8,  0, 0,   5, 0,   5, 1, "R6 mem off wb on");
    // Load followed by use on a: stall, bubble, then writeback bypass
    drive(12,  2,  1,  1, 12, 1,   0, 0,   0, 0, "R7 load-use a");
    drive(12,  2,  0,  0,  0, 0,  12, 1,   0, 0, "R8 after bubble");
    drive( 0,  0, 12,  2,  0, 0,   0, 0,  12, 1, "R3 load result bypass");
    drive( 3, 14,  0,  0, 14, 1,   0, 0,   0, 0, "R7 load-use b");
    drive( 3,  6,  0,  0, 14, 1,   0, 0,   0, 0, "R8 load unrelated");
    drive( 3,  6,  0,  0,  3, 0,   0, 0,   0, 0, "R8 alu producer no stall");
    drive( 0,  0,  0,  0,  0, 1,   0, 0,   0, 0, "R9 load to r0");
    drive( 0,  5,  7, 11,  0, 1,   7, 1,  11, 1, "R10 a mem b wb");
    drive(31, 31, 31, 31, 31, 1,  31, 1,  31, 1, "R4 top register");
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule